// File: doc/BRIEF.md
# Quasi-Resonant Valley Switching Sequencer

This block sets the moment a flyback power switch turns on again after each off-time. The drain voltage rings once the magnetic energy has been delivered. A zero-crossing comparator on the auxiliary winding reports that ringing as a one-bit signal, and every falling transition of it marks a valley. The block counts those valleys and raises a one-cycle turn-on request at the chosen valley. That is the first valley at low line and the second at high line.

The line range comes from a one-bit line comparator whose analog hysteresis lies outside this block. Inside, the comparator result must hold steady for a qualification period before the range is accepted. The valley number is captured when the drive falls and holds for the whole off-time. A blanking window right after the on-time masks the turn-off ringing. When the ringing is too damped to cross the threshold, a timeout inserts a substitute valley. Both comparator inputs pass through a synchronizer. All durations are given in clock cycles.

Top module: `qr_valley_seq`

## Requirements
- R1: After reset, `ton_req` and `line_high` are 0, and no valley produces a request until the drive has completed an on/off sequence.
- R2: A valley is a 1-to-0 transition of `zcd_cmp`, where 1 means the winding voltage is above threshold. At a valley that meets the target, `ton_req` is high after the third rising clock edge that follows the change of `zcd_cmp`: two synchronizer flops, then the output register.
- R3: With `line_high` = 0 the request comes at the 1st valley of the off-time. With `line_high` = 1 it comes at the 2nd valley.
- R4: Valleys that arrive within BLANK_CYC cycles after `drv_on` falls are not counted.
- R5: Outside blanking, while the synchronized `zcd_cmp` stays at 0 for TIMEOUT_CYC cycles, a substitute valley is counted. This repeats every TIMEOUT_CYC cycles for as long as the input stays low.
- R6: `line_high` takes the synchronized `line_cmp` value only after the two have differed for LINE_QUAL_CYC consecutive cycles. A shorter excursion leaves `line_high` unchanged. This holds in both directions.
- R7: The valley target is captured from `line_high` when `drv_on` falls. A change of `line_high` later in that off-time does not alter it.
- R8: `ton_req` lasts one cycle, and at most one request is issued per off-time. Later valleys are ignored until `drv_on` rises again.
- R9: While `hold_off` is 1, no request is issued. The valley count stays at the target, and the first valley after `hold_off` returns to 0 issues the request.
- R10: A rising edge of `drv_on` clears the valley count. No request is issued in the cycle after `drv_on` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zcd_cmp | input | 1 | Zero-crossing comparator output, asynchronous, 1 = above threshold |
| line_cmp | input | 1 | Line-range comparator output, asynchronous, 1 = high line |
| drv_on | input | 1 | Current state of the switch drive, 1 = on |
| hold_off | input | 1 | Suppresses turn-on requests while 1 |
| ton_req | output | 1 | One-cycle turn-on request |
| line_high | output | 1 | Qualified line range, 1 = high line |

## Verification
The bench drives clean valleys at low line and at high line. These show the first-valley and second-valley choices apart, and pin the three-cycle latency. It places falls inside the blanking window and after it, so a masked valley that is wrongly counted shows up as an early request. Held-low inputs, with and without an earlier real valley, separate the timeout's substitute valleys from real ones. Line glitches, a line change in the middle of an off-time, a drive restart in the middle of a count, and hold-off periods separate qualification, locking, clearing and suppression.

// File: rtl/qrv_pkg.sv
`timescale 1ns/1ps
package qrv_pkg;
   typedef enum logic [1:0] {
      QRV_IDLE  = 2'd0,
      QRV_ON    = 2'd1,
      QRV_BLANK = 2'd2,
      QRV_HUNT  = 2'd3
   } qrv_state_t;
endpackage

// File: rtl/qrv_sync.sv
`timescale 1ns/1ps
module qrv_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 1) begin : g_one
         logic [W-1:0] st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= RST_VAL;
            else        st <= d;
         end
         assign q = st;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= {STAGES{RST_VAL}};
            else        st <= {st[STAGES-2:0], d};
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/qrv_line_qual.sv
`timescale 1ns/1ps
module qrv_line_qual #(
   parameter int QUAL_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_s,
   output logic line_high
);
   localparam int QW = (QUAL_CYC < 2) ? 1 : $clog2(QUAL_CYC + 1);
   localparam logic [QW-1:0] QLIM = QW'(QUAL_CYC - 1);

   logic [QW-1:0] qcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qcnt      <= '0;
         line_high <= 1'b0;
      end else if (line_s != line_high) begin
         if (qcnt == QLIM) begin
            line_high <= line_s;
            qcnt      <= '0;
         end else begin
            qcnt <= qcnt + 1'b1;
         end
      end else begin
         qcnt <= '0;
      end
   end
endmodule

// File: rtl/qrv_timeout.sv
`timescale 1ns/1ps
module qrv_timeout #(
   parameter int TIMEOUT_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic zcd_s,
   output logic tick
);
   localparam int TW = $clog2(TIMEOUT_CYC);
   localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_CYC - 1);

   logic [TW-1:0] tcnt;

   assign tick = en & ~zcd_s & (tcnt == TLIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tcnt <= '0;
      else if (!en || zcd_s)   tcnt <= '0;
      else if (tcnt == TLIM)   tcnt <= '0;
      else                     tcnt <= tcnt + 1'b1;
   end
endmodule

// File: rtl/qrv_valley_eng.sv
`timescale 1ns/1ps
module qrv_valley_eng
   import qrv_pkg::*;
#(
   parameter int BLANK_CYC   = 8,
   parameter int TIMEOUT_CYC = 8,
   parameter int LO_VALLEY   = 1,
   parameter int HI_VALLEY   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zcd_s,
   input  logic line_high,
   input  logic drv_on,
   input  logic hold_off,
   output logic ton_req
);
   localparam int VMAX = (HI_VALLEY > LO_VALLEY) ? HI_VALLEY : LO_VALLEY;
   localparam int VW   = $clog2(VMAX + 1);
   localparam int BW   = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC + 1);
   localparam logic [VW-1:0] V_LO = VW'(LO_VALLEY);
   localparam logic [VW-1:0] V_HI = VW'(HI_VALLEY);

   qrv_state_t    state;
   logic          drv_q, zcd_d;
   logic [VW-1:0] vcnt, target, vnext;
   logic [BW-1:0] bcnt;
   logic          hunting, tick, zfall, vevent, hit, drv_rise, drv_fall;

   assign hunting  = (state == QRV_HUNT);
   assign drv_rise = drv_on & ~drv_q;
   assign drv_fall = ~drv_on & drv_q;
   assign zfall    = zcd_d & ~zcd_s;

   qrv_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (hunting),
      .zcd_s (zcd_s),
      .tick  (tick)
   );

   assign vevent = hunting & (zfall | tick);
   assign vnext  = (vcnt >= target) ? vcnt : vcnt + 1'b1;
   assign hit    = vevent & (vnext == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= QRV_IDLE;
         drv_q   <= 1'b0;
         zcd_d   <= 1'b1;
         vcnt    <= '0;
         target  <= V_LO;
         bcnt    <= '0;
         ton_req <= 1'b0;
      end else begin
         drv_q   <= drv_on;
         zcd_d   <= zcd_s;
         ton_req <= 1'b0;
         if (drv_rise) begin
            state <= QRV_ON;
            vcnt  <= '0;
         end else begin
            case (state)
               QRV_ON: begin
                  if (drv_fall) begin
                     state  <= QRV_BLANK;
                     bcnt   <= BW'(BLANK_CYC - 1);
                     target <= line_high ? V_HI : V_LO;
                  end
               end
               QRV_BLANK: begin
                  if (bcnt == '0) state <= QRV_HUNT;
                  else            bcnt  <= bcnt - 1'b1;
               end
               QRV_HUNT: begin
                  if (vevent) begin
                     vcnt <= vnext;
                     if (hit && !hold_off) begin
                        ton_req <= 1'b1;
                        state   <= QRV_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/qr_valley_seq.sv
`timescale 1ns/1ps
module qr_valley_seq #(
   parameter int SYNC_STAGES   = 2,
   parameter int BLANK_CYC     = 300,
   parameter int TIMEOUT_CYC   = 650,
   parameter int LINE_QUAL_CYC = 2500000,
   parameter int LO_VALLEY     = 1,
   parameter int HI_VALLEY     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zcd_cmp,
   input  logic line_cmp,
   input  logic drv_on,
   input  logic hold_off,
   output logic ton_req,
   output logic line_high
);
   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (BLANK_CYC < 1) begin : g_bad_blank
         $error("BLANK_CYC must be at least 1");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_tmo
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (LINE_QUAL_CYC < 1) begin : g_bad_qual
         $error("LINE_QUAL_CYC must be at least 1");
      end
      if (LO_VALLEY < 1 || HI_VALLEY < LO_VALLEY) begin : g_bad_valley
         $error("valley numbers must satisfy 1 <= LO_VALLEY <= HI_VALLEY");
      end
   endgenerate

   logic [1:0] sync_q;
   logic       zcd_s, line_s;

   qrv_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({line_cmp, zcd_cmp}),
      .q     (sync_q)
   );
   assign zcd_s  = sync_q[0];
   assign line_s = sync_q[1];

   qrv_line_qual #(.QUAL_CYC(LINE_QUAL_CYC)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_s    (line_s),
      .line_high (line_high)
   );

   qrv_valley_eng #(
      .BLANK_CYC   (BLANK_CYC),
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .LO_VALLEY   (LO_VALLEY),
      .HI_VALLEY   (HI_VALLEY)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .zcd_s     (zcd_s),
      .line_high (line_high),
      .drv_on    (drv_on),
      .hold_off  (hold_off),
      .ton_req   (ton_req)
   );
endmodule

// File: rtl/qr_valley_seq_chk.sv
`timescale 1ns/1ps
module qr_valley_seq_chk #(
   parameter int LINE_QUAL_CYC = 16
) (
   input logic clk,
   input logic rst_n,
   input logic drv_on,
   input logic hold_off,
   input logic ton_req,
   input logic line_high,
   input logic line_s
);
   localparam int CW = $clog2(LINE_QUAL_CYC + 2);
   localparam logic [CW-1:0] CMAX = CW'(LINE_QUAL_CYC);

   logic          armed;
   logic [CW-1:0] dis_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         dis_cnt <= '0;
      end else begin
         if (drv_on)       armed <= 1'b0;
         else if (ton_req) armed <= 1'b1;
         if (line_s == line_high) dis_cnt <= '0;
         else if (dis_cnt != CMAX) dis_cnt <= dis_cnt + 1'b1;
      end
   end

   // R9
   hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_off |=> !ton_req);

   // R10
   drv_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_on |=> !ton_req);

   // R8
   one_per_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> !ton_req);

   // R6
   line_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_high != $past(line_high)) |-> ($past(dis_cnt) >= CW'(LINE_QUAL_CYC - 1)));
endmodule

bind qr_valley_seq qr_valley_seq_chk #(.LINE_QUAL_CYC(LINE_QUAL_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .drv_on    (drv_on),
   .hold_off  (hold_off),
   .ton_req   (ton_req),
   .line_high (line_high),
   .line_s    (line_s)
);

// File: tb/sim_qr_valley_seq.sv
`timescale 1ns/1ps
module sim_qr_valley_seq;
   localparam int B = 8;
   localparam int T = 20;
   localparam int Q = 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic zcd_cmp = 1'b1;
   logic line_cmp = 1'b0;
   logic drv_on = 1'b0;
   logic hold_off = 1'b0;
   logic ton_req, line_high;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   qr_valley_seq #(
      .SYNC_STAGES(2), .BLANK_CYC(B), .TIMEOUT_CYC(T),
      .LINE_QUAL_CYC(Q), .LO_VALLEY(1), .HI_VALLEY(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .zcd_cmp(zcd_cmp), .line_cmp(line_cmp),
      .drv_on(drv_on), .hold_off(hold_off), .ton_req(ton_req), .line_high(line_high)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One valley: zcd drops, then returns high; exp_idx = negedge of the request, 0 = none
   task automatic ring(input int exp_idx, input string tag);
      int first = 0;
      int highs = 0;
      @(negedge clk) zcd_cmp = 1'b0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         if (ton_req) begin
            highs++;
            if (first == 0) first = i;
         end
         if (i == 2) zcd_cmp = 1'b1;
      end
      check(first == exp_idx, tag, first, exp_idx);
      if (exp_idx != 0) check(highs == 1, {tag, " single-cycle width"}, highs, 1);
   endtask

   // drive on for three cycles, then off, then wait past blanking
   task automatic drv_cycle();
      @(negedge clk) drv_on = 1'b1;
      repeat (3) @(negedge clk);
      drv_on = 1'b0;
      repeat (B + 4) @(negedge clk);
   endtask

   task automatic set_line(input bit v, input string tag);
      @(negedge clk) line_cmp = v;
      repeat (Q + 6) @(negedge clk);
      check(line_high == v, tag, line_high, v);
   endtask

   // drive cycle with zcd already low; returns negedge index of first request after drive falls
   task automatic off_measure(output int idx);
      @(negedge clk) drv_on = 1'b1;
      repeat (3) @(negedge clk);
      drv_on = 1'b0;
      idx = 0;
      for (int i = 1; i <= 150; i++) begin
         @(negedge clk);
         if (ton_req && idx == 0) idx = i;
      end
   endtask

   task automatic t_reset();
      check(ton_req == 1'b0, "R1 ton_req after reset", ton_req, 0);
      check(line_high == 1'b0, "R1 line_high after reset", line_high, 0);
      ring(0, "R1 valley before any drive");
   endtask

   task automatic t_low_line();
      drv_cycle();
      ring(3, "R2 R3 low line first valley");
      ring(0, "R8 later valley same off-time");
   endtask

   task automatic t_high_line();
      set_line(1'b1, "R6 line rises after qualification");
      drv_cycle();
      ring(0, "R3 high line first valley skipped");
      ring(3, "R3 high line second valley");
   endtask

   task automatic t_blank();
      @(negedge clk) drv_on = 1'b1;
      repeat (3) @(negedge clk);
      drv_on = 1'b0;
      @(negedge clk) zcd_cmp = 1'b0;
      repeat (2) @(negedge clk);
      zcd_cmp = 1'b1;
      repeat (B + 4) @(negedge clk);
      ring(0, "R4 blanked valley not counted");
      ring(3, "R4 second real valley at high line");
   endtask

   task automatic t_restart();
      drv_cycle();
      ring(0, "R10 one valley counted");
      drv_cycle();
      ring(0, "R10 count cleared by drive rise");
      ring(3, "R10 second valley after restart");
   endtask

   task automatic t_lock();
      drv_cycle();
      set_line(1'b0, "R6 line falls after qualification");
      ring(0, "R7 target stays at second valley");
      ring(3, "R7 locked second valley");
   endtask

   task automatic t_glitch();
      @(negedge clk) line_cmp = 1'b1;
      repeat (Q / 2) @(negedge clk);
      line_cmp = 1'b0;
      repeat (Q + 6) @(negedge clk);
      check(line_high == 1'b0, "R6 short line excursion ignored", line_high, 0);
   endtask

   task automatic t_hold();
      drv_cycle();
      @(negedge clk) hold_off = 1'b1;
      ring(0, "R9 request withheld by hold_off");
      @(negedge clk) hold_off = 1'b0;
      ring(3, "R9 next valley after release");
   endtask

   task automatic t_timeout();
      int idx;
      @(negedge clk) zcd_cmp = 1'b0;
      repeat (4) @(negedge clk);
      off_measure(idx);
      // low line: blank then one timeout period
      check(idx >= B + T && idx <= B + T + 2, "R5 timeout valley low line", idx, B + T + 1);
      set_line(1'b1, "R6 line high for timeout test");
      off_measure(idx);
      check(idx >= B + 2 * T && idx <= B + 2 * T + 2, "R5 two timeouts high line", idx, B + 2 * T + 1);
      @(negedge clk) zcd_cmp = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_mixed();
      int idx = 0;
      drv_cycle();
      @(negedge clk) zcd_cmp = 1'b0;
      for (int i = 1; i <= 60; i++) begin
         @(negedge clk);
         if (ton_req && idx == 0) idx = i;
      end
      check(idx >= T + 1 && idx <= T + 3, "R5 real valley then timeout valley", idx, T + 2);
      @(negedge clk) zcd_cmp = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_low_line();
      t_glitch();
      t_hold();
      t_high_line();
      t_blank();
      t_restart();
      t_lock();
      t_timeout();
      t_mixed();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule